// File: doc/BRIEF.md
# Cache maintenance completion tracker

This block sits in a coherent interconnect at the level that a cache clean or clean-and-invalidate operation names as its destination. Two streams of traffic pass it. One is the clean request itself, which has already travelled down through every cache level. The other is a write-clean packet, which carries dirty data to the level below. A cache produces a write-clean only when it held the line dirty, and that packet is tagged with the clean request's transaction ID. The tracker pairs the two pieces by that shared ID. It sends one completion response upstream once every piece the transaction needs has crossed.

Each clean request carries a flag saying whether a write-clean will follow. The two pieces may arrive in either order, or in the same cycle. Whichever piece arrives first takes an entry in a small table, and the entry is freed when the response handshake completes. A write-clean that is not tagged as part of a clean operation is accepted and forgotten. When the table has no free entry, any piece that would need a new entry is held off with its ready signal.

Top module: `cmo_done_tracker`

## Requirements
- R1: After reset no response is offered (`rspValid`=0), and both `reqReady` and `wcReady` are high.
- R2: A clean request accepted with `reqWbPending`=0 and no earlier write-clean for its ID is complete at once, so `rspValid` is high in the cycle after the request handshake and `rspId` presents that ID.
- R3: A clean request accepted with `reqWbPending`=1 produces no response until a write-clean with `wcForClean`=1 and the same ID is accepted; the response is offered in the cycle after that write-clean handshake.
- R4: A write-clean with `wcForClean`=1 that arrives before its clean request takes an entry. The later clean request for that ID completes the transaction whatever its `reqWbPending` value, and the response follows one cycle after the request handshake.
- R5: A write-clean with `wcForClean`=0 is always accepted (`wcReady`=1) and creates, completes and frees no entry.
- R6: The table holds `DEPTH` (default 8) transactions, counting those still waiting for their response handshake. A piece that needs a new entry sees ready low when every entry is in use. A piece whose ID matches an entry waiting for that kind of piece is always ready.
- R7: While `rspValid` is high and `rspReady` is low, the response stays valid and `rspId` stays unchanged.
- R8: `rspValid` is high exactly when at least one transaction is complete. Each completed transaction is answered once, with its own ID, and its entry is freed on the handshake.
- R9: A clean request and a write-clean (`wcForClean`=1) with the same new ID, accepted in the same cycle, share one entry, and the response is offered in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A clean request is crossing |
| reqReady | output | 1 | Tracker can accept the clean request |
| reqId | input | ID_W | Transaction ID of the clean request |
| reqWbPending | input | 1 | 1: a write-clean for this ID will follow |
| wcValid | input | 1 | A write-clean packet is crossing |
| wcReady | output | 1 | Tracker can accept the write-clean |
| wcId | input | ID_W | Transaction ID of the write-clean |
| wcForClean | input | 1 | 1: the write-clean belongs to a clean operation |
| rspValid | output | 1 | A completion response is offered |
| rspReady | input | 1 | Upstream takes the completion response |
| rspId | output | ID_W | Transaction ID of the offered response |

## Verification
Assertions check the cycle-level rules on every cycle. Untagged write-cleans are never stalled. A free entry always grants a new request. A held response keeps its ID. A new entry is only ever written into a free slot, and a response frees only an entry that is complete. A request with no pending write-back always raises the response on the next cycle. Only the bench scenarios can show the pairing across time: a response waits for the late write-clean, the write-clean-first order completes, a full table stalls new IDs but passes matching ones, and every completed ID is answered once and only once. The bench checks these against a per-ID model under random mixes of order and back-pressure.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  parameter int unsigned CMT_DEPTH_DEF = 8;
  parameter int unsigned CMT_ID_W_DEF  = 4;

  // Progress flags of one table slot.
  typedef struct packed {
    logic used;     // slot holds a transaction
    logic sawReq;   // clean request has crossed
    logic sawWc;    // write-clean has crossed
    logic wantWc;   // a write-clean is expected
  } slotFlags_t;

  function automatic logic slotDone(slotFlags_t f);
    return f.used && f.sawReq && (f.sawWc || !f.wantWc);
  endfunction

endpackage

// File: rtl/cmt_table.sv
module cmt_table
  import cmt_pkg::*;
#(
  parameter int unsigned DEPTH = CMT_DEPTH_DEF,
  parameter int unsigned ID_W  = CMT_ID_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ID_W-1:0]  reqId,
  input  logic             reqWbPending,
  input  logic [ID_W-1:0]  wcId,
  input  logic [DEPTH-1:0] reqSet,
  input  logic [DEPTH-1:0] reqAlloc,
  input  logic [DEPTH-1:0] wcSet,
  input  logic [DEPTH-1:0] wcAlloc,
  input  logic [DEPTH-1:0] clrMask,
  input  logic [DEPTH-1:0] selMask,
  output logic [DEPTH-1:0] reqMatch,
  output logic [DEPTH-1:0] wcMatch,
  output logic [DEPTH-1:0] freeMask,
  output logic [DEPTH-1:0] doneMask,
  output logic [ID_W-1:0]  rspId
);

  slotFlags_t          flags [DEPTH];
  logic [ID_W-1:0]     slotId [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flags[g]  <= '0;
        slotId[g] <= '0;
      end else if (clrMask[g]) begin
        flags[g] <= '0;
      end else if (reqAlloc[g] || wcAlloc[g]) begin
        flags[g].used   <= 1'b1;
        flags[g].sawReq <= reqSet[g];
        flags[g].sawWc  <= wcSet[g];
        flags[g].wantWc <= reqSet[g] ? reqWbPending : 1'b1;
        slotId[g]       <= reqAlloc[g] ? reqId : wcId;
      end else begin
        if (reqSet[g]) begin
          flags[g].sawReq <= 1'b1;
          flags[g].wantWc <= reqWbPending;
        end
        if (wcSet[g]) begin
          flags[g].sawWc <= 1'b1;
        end
      end
    end

    always_comb begin
      reqMatch[g] = flags[g].used && !flags[g].sawReq && (slotId[g] == reqId);
      wcMatch[g]  = flags[g].used && !flags[g].sawWc &&
                    !(flags[g].sawReq && !flags[g].wantWc) && (slotId[g] == wcId);
      freeMask[g] = !flags[g].used;
      doneMask[g] = slotDone(flags[g]);
    end
  end

  always_comb begin
    rspId = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (selMask[i]) rspId = rspId | slotId[i];
    end
  end

  // R6: a new transaction is only ever written into an unused slot
  p_alloc_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((reqAlloc | wcAlloc) & ~freeMask) == '0);

  // R8: a response handshake only frees a completed slot
  p_clear_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clrMask & ~doneMask) == '0);

endmodule

// File: rtl/cmt_ctrl.sv
module cmt_ctrl #(
  parameter int unsigned DEPTH = cmt_pkg::CMT_DEPTH_DEF,
  parameter int unsigned ID_W  = cmt_pkg::CMT_ID_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [ID_W-1:0]  reqId,
  input  logic             wcValid,
  input  logic [ID_W-1:0]  wcId,
  input  logic             wcForClean,
  input  logic             rspReady,
  input  logic [DEPTH-1:0] reqMatch,
  input  logic [DEPTH-1:0] wcMatch,
  input  logic [DEPTH-1:0] freeMask,
  input  logic [DEPTH-1:0] doneMask,
  output logic             reqReady,
  output logic             wcReady,
  output logic             rspValid,
  output logic [DEPTH-1:0] reqSet,
  output logic [DEPTH-1:0] reqAlloc,
  output logic [DEPTH-1:0] wcSet,
  output logic [DEPTH-1:0] wcAlloc,
  output logic [DEPTH-1:0] clrMask,
  output logic [DEPTH-1:0] selMask
);

  localparam logic [DEPTH-1:0] ONE = DEPTH'(1);

  logic [DEPTH-1:0] freeA, freeRest, freeB, doneLow, wcSlot, holdMask;
  logic reqHit, wcHit, haveA, haveB, sameNew, reqFire, reqTakes, wcFire, holdQ;

  always_comb begin
    // lowest and second-lowest free slot
    freeA    = freeMask & (~freeMask + ONE);
    freeRest = freeMask & ~freeA;
    freeB    = freeRest & (~freeRest + ONE);
    haveA    = |freeA;
    haveB    = |freeB;

    reqHit   = |reqMatch;
    wcHit    = |wcMatch;
    sameNew  = reqValid && wcValid && wcForClean && (reqId == wcId) && !reqHit && !wcHit;

    reqReady = reqHit || haveA;
    reqFire  = reqValid && reqReady;
    reqTakes = reqFire && !reqHit;

    if (!wcForClean || wcHit)  wcReady = 1'b1;
    else if (sameNew)          wcReady = haveA;
    else if (reqTakes)         wcReady = haveB;
    else                       wcReady = haveA;
    wcFire = wcValid && wcReady && wcForClean;

    reqSet   = reqFire  ? (reqHit ? reqMatch : freeA) : '0;
    reqAlloc = reqTakes ? freeA : '0;

    if (wcHit)         wcSlot = wcMatch;
    else if (sameNew)  wcSlot = freeA;
    else if (reqTakes) wcSlot = freeB;
    else               wcSlot = freeA;
    wcSet   = wcFire ? wcSlot : '0;
    wcAlloc = (wcFire && !wcHit && !sameNew) ? wcSlot : '0;

    // response selection: keep the offered slot while stalled
    doneLow  = doneMask & (~doneMask + ONE);
    selMask  = holdQ ? holdMask : doneLow;
    rspValid = |selMask;
    clrMask  = (rspValid && rspReady) ? selMask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ    <= 1'b0;
      holdMask <= '0;
    end else begin
      holdQ    <= rspValid && !rspReady;
      holdMask <= selMask;
    end
  end

  // R5: untagged write-cleans are never stalled
  p_plain_wc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wcValid && !wcForClean) |-> wcReady);

  // R6: a free slot always grants a clean request
  p_grant_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (|freeMask)) |-> reqReady);

  // R8: at most one slot is answered at a time
  p_sel_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selMask));

  // R9: two new pieces never land in the same slot as separate allocations
  p_alloc_apart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqAlloc & wcAlloc) == '0);

endmodule

// File: rtl/cmo_done_tracker.sv
module cmo_done_tracker #(
  parameter int unsigned DEPTH = cmt_pkg::CMT_DEPTH_DEF,
  parameter int unsigned ID_W  = cmt_pkg::CMT_ID_W_DEF
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [ID_W-1:0] reqId,
  input  logic            reqWbPending,
  input  logic            wcValid,
  output logic            wcReady,
  input  logic [ID_W-1:0] wcId,
  input  logic            wcForClean,
  output logic            rspValid,
  input  logic            rspReady,
  output logic [ID_W-1:0] rspId
);

  logic [DEPTH-1:0] reqSet, reqAlloc, wcSet, wcAlloc, clrMask, selMask;
  logic [DEPTH-1:0] reqMatch, wcMatch, freeMask, doneMask;

  cmt_ctrl #(.DEPTH(DEPTH), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqId(reqId),
    .wcValid(wcValid), .wcId(wcId), .wcForClean(wcForClean),
    .rspReady(rspReady),
    .reqMatch(reqMatch), .wcMatch(wcMatch), .freeMask(freeMask), .doneMask(doneMask),
    .reqReady(reqReady), .wcReady(wcReady), .rspValid(rspValid),
    .reqSet(reqSet), .reqAlloc(reqAlloc), .wcSet(wcSet), .wcAlloc(wcAlloc),
    .clrMask(clrMask), .selMask(selMask)
  );

  cmt_table #(.DEPTH(DEPTH), .ID_W(ID_W)) u_table (
    .clk(clk), .rstN(rstN),
    .reqId(reqId), .reqWbPending(reqWbPending), .wcId(wcId),
    .reqSet(reqSet), .reqAlloc(reqAlloc), .wcSet(wcSet), .wcAlloc(wcAlloc),
    .clrMask(clrMask), .selMask(selMask),
    .reqMatch(reqMatch), .wcMatch(wcMatch), .freeMask(freeMask), .doneMask(doneMask),
    .rspId(rspId)
  );

  // R7: a stalled response keeps its ID
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspId)));

  // R2: a request with nothing to wait for raises the response next cycle
  p_quick_rsp_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWbPending) |=> rspValid);

endmodule

// File: tb/cmo_done_tracker_bench.sv
`timescale 1ns/100ps
module cmo_done_tracker_bench;

  localparam int DEPTH = 8;
  localparam int ID_W  = 4;
  localparam int NID   = 1 << ID_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWbPending = 1'b0, wcValid = 1'b0, wcForClean = 1'b0, rspReady = 1'b0;
  logic [ID_W-1:0] reqId = '0, wcId = '0;
  logic reqReady, wcReady, rspValid;
  logic [ID_W-1:0] rspId;

  always #2.5 clk = ~clk;

  cmo_done_tracker #(.DEPTH(DEPTH), .ID_W(ID_W)) u_cmo_done_tracker (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqId(reqId), .reqWbPending(reqWbPending),
    .wcValid(wcValid), .wcReady(wcReady), .wcId(wcId), .wcForClean(wcForClean),
    .rspValid(rspValid), .rspReady(rspReady), .rspId(rspId)
  );

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  // per-ID reference model
  bit mAct [NID];
  bit mReq [NID];
  bit mWc  [NID];
  bit mNeed[NID];

  function automatic bit mDone(int i);
    return mAct[i] && mReq[i] && (mWc[i] || !mNeed[i]);
  endfunction

  function automatic int mCount();
    int c = 0;
    for (int i = 0; i < NID; i++) c += mAct[i];
    return c;
  endfunction

  function automatic bit mAnyDone();
    bit d = 0;
    for (int i = 0; i < NID; i++) d |= mDone(i);
    return d;
  endfunction

  function automatic bit expReqRdy(int rid);
    bit hit = mAct[rid] && !mReq[rid];
    return hit || (mCount() < DEPTH);
  endfunction

  function automatic bit expWcRdy(bit rv, int rid, int wid, bit cmo);
    bit hit, same, reqNew;
    if (!cmo) return 1'b1;
    hit = mAct[wid] && !mWc[wid] && !(mReq[wid] && !mNeed[wid]);
    if (hit) return 1'b1;
    same = rv && (rid == wid) && !mAct[wid];
    if (same) return mCount() < DEPTH;
    reqNew = rv && !(mAct[rid] && !mReq[rid]);
    return (mCount() + (reqNew ? 1 : 0)) < DEPTH;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, commit at posedge, check next negedge
  task automatic step(bit rv, int rid, bit rneed, bit wv, int wid, bit wcmo, bit rrdy);
    bit eR, eW, rF, wF, sF, hold;
    int sId;
    reqValid = rv; reqId = rid[ID_W-1:0]; reqWbPending = rneed;
    wcValid = wv; wcId = wid[ID_W-1:0]; wcForClean = wcmo;
    rspReady = rrdy;
    #1;
    eR = expReqRdy(rid);
    eW = expWcRdy(rv, rid, wid, wcmo);
    if (rv) check(reqReady == eR, "R6 reqReady", reqReady, eR);
    if (wv) check(wcReady == eW, wcmo ? "R6 wcReady" : "R5 wcReady", wcReady, eW);
    rF = rv && reqReady;
    wF = wv && wcReady && wcmo;
    sF = rspValid && rrdy;
    sId = rspId;
    hold = rspValid && !rrdy;
    @(posedge clk);
    #1;
    if (sF) begin mAct[sId] = 0; mReq[sId] = 0; mWc[sId] = 0; mNeed[sId] = 0; end
    if (rF) begin mAct[rid] = 1; mReq[rid] = 1; mNeed[rid] = rneed; end
    if (wF) begin mAct[wid] = 1; mWc[wid] = 1; end
    @(negedge clk);
    check(rspValid == mAnyDone(), "R8 rspValid", rspValid, mAnyDone());
    if (rspValid) check(mDone(rspId), "R8 rspId complete", rspId, 1);
    if (hold) check(rspValid && (rspId == sId), "R7 held rspId", rspId, sId);
  endtask

  task automatic idle(bit rrdy);
    step(0, 0, 0, 0, 0, 0, rrdy);
  endtask

  initial begin
    for (int i = 0; i < NID; i++) begin mAct[i] = 0; mReq[i] = 0; mWc[i] = 0; mNeed[i] = 0; end
    void'($urandom(32'h00C1_EA5E));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check(rspValid == 0, "R1 rspValid", rspValid, 0);
    check(reqReady == 1, "R1 reqReady", reqReady, 1);
    check(wcReady == 1, "R1 wcReady", wcReady, 1);
    @(negedge clk);

    // R2: no write-back pending, response next cycle
    step(1, 3, 0, 0, 0, 0, 0);
    check(rspValid && rspId == 3, "R2 quick response", rspId, 3);
    idle(1);

    // R3: response waits for the write-clean
    step(1, 5, 1, 0, 0, 0, 1);
    check(rspValid == 0, "R3 waiting", rspValid, 0);
    idle(1);
    check(rspValid == 0, "R3 still waiting", rspValid, 0);
    step(0, 0, 0, 1, 5, 1, 0);
    check(rspValid && rspId == 5, "R3 after write-clean", rspId, 5);
    idle(1);

    // R4: write-clean first, request completes it
    step(0, 0, 0, 1, 6, 1, 1);
    check(rspValid == 0, "R4 write-clean alone", rspValid, 0);
    step(1, 6, 0, 0, 0, 0, 0);
    check(rspValid && rspId == 6, "R4 request second", rspId, 6);
    idle(1);

    // R5: untagged write-clean changes nothing
    step(0, 0, 0, 1, 9, 0, 1);
    check(rspValid == 0, "R5 untagged no response", rspValid, 0);

    // R9: both pieces in the same cycle
    step(1, 7, 1, 1, 7, 1, 0);
    check(rspValid && rspId == 7, "R9 joint arrival", rspId, 7);
    idle(1);

    // R6: fill the table, then stall new IDs but pass a matching piece
    for (int i = 0; i < DEPTH; i++) step(1, i, 1, 0, 0, 0, 0);
    step(1, 8, 1, 0, 0, 0, 0);
    check(reqReady == 0, "R6 full stalls request", reqReady, 0);
    step(0, 0, 0, 1, 9, 1, 0);
    check(wcReady == 0, "R6 full stalls write-clean", wcReady, 0);
    step(0, 0, 0, 1, 0, 1, 0);
    check(rspValid && rspId == 0, "R6 matching write-clean passes", rspId, 0);
    idle(0);
    idle(0);
    idle(1);
    for (int i = 1; i < DEPTH; i++) step(0, 0, 0, 1, i, 1, 1);
    repeat (DEPTH + 2) idle(1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int id = $urandom % NID;
      bit rr = ($urandom % 4) != 0;
      int pick = $urandom % 3;
      if (!mAct[id]) begin
        if (pick == 0)      step(1, id, 0, 0, 0, 0, rr);
        else if (pick == 1) step(1, id, 1, 0, 0, 0, rr);
        else                step(0, 0, 0, 1, id, 1, rr);
      end else if (mDone(id)) begin
        step(0, 0, 0, 1, id, 0, rr);
      end else if (mReq[id]) begin
        step(0, 0, 0, 1, id, 1, rr);
      end else begin
        step(1, id, pick[0], 0, 0, 0, rr);
      end
    end

    // drain
    for (int i = 0; i < NID; i++) if (mAct[i] && !mReq[i]) step(1, i, 1, 0, 0, 0, 1);
    for (int i = 0; i < NID; i++) if (mAct[i] && !mWc[i] && mNeed[i]) step(0, 0, 0, 1, i, 1, 1);
    repeat (NID + 4) idle(1);
    check(rspValid == 0 && mCount() == 0, "R8 all answered", mCount(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule